// File: doc/BRIEF.md
# Queue Status and Interrupt Register Bank

This block is the status and interrupt register bank of a 64-queue hardware queue manager. Each queue's fill-level conditions arrive as live inputs from pointer logic outside the block. Under-run and over-run events arrive as one-cycle pulses. The bank packs these inputs into 32-bit words that software reads over a simple single-cycle register bus. It also holds the interrupt configuration and the interrupt flags, and it drives one interrupt line for each group of 32 queues.

The two groups do not get the same treatment. The lower group (queues 0 to 31) reports a 4-bit condition nibble per queue. It keeps sticky under-run and over-run flags, and each queue can choose which condition raises its interrupt. The upper group (queues 32 to 63) reports only nearly-empty and full. Its interrupt always comes from nearly-empty.

Flags work in one of two modes. In level mode a flag tracks its enabled condition. In latched mode a flag captures a rising edge of the condition and holds until software clears it.

Top module: `qsib_irq_bank`

## Requirements
- R1: The lower-group status words are at word indices 0 to 3 and cannot be written. Queue q sits in word q/8 at bits (q mod 8)*4 upward. Nibble bit 0 is empty, bit 1 nearly empty, bit 2 nearly full and bit 3 full. The read returns the live condition inputs.
- R2: A pulse on `low_uf[q]` sets bit 2*(q mod 16) of word 4+q/16 on the next clock. A pulse on `low_of[q]` sets the bit one position higher.
- R3: Under-run and over-run bits hold until cleared. Writing word 4 or 5 clears each bit written as 0 and leaves each bit written as 1. If a pulse arrives in the same cycle as a clearing write, the bit stays set.
- R4: Word 6 bit (q-32) is the nearly-empty input of upper queue q. Word 7 bit (q-32) is its full input. Both words are read-only.
- R5: Words 8 to 11 hold a 4-bit source field per lower queue, with the same placement as R1, and read back what was written. In each field, bits [1:0] choose the nibble bit (0 empty, 1 nearly empty, 2 nearly full, 3 full) and bit 2 inverts it.
- R6: In level mode, one clock after the inputs are applied, each flag equals its selected condition AND its enable bit. Word 12 holds the lower-group enables (bit q) and word 13 the upper-group enables (bit q-32). Software writes to the flag words have no lasting effect in this mode.
- R7: Bit 3 of word 8 selects latched mode. In latched mode a flag sets on a rising edge of its enabled condition and holds. Writing 1 to a flag bit in word 14 or 15 clears it. A new edge in the same cycle as the clearing write leaves the flag set. A condition that stays high does not set the flag again.
- R8: The interrupt condition for upper queues is always their nearly-empty input.
- R9: `irq_lo` is the OR of the 32 flags in word 14. `irq_up` is the OR of the 32 flags in word 15.
- R10: Reset clears every stored word (4, 5, 8 to 15) to zero and drives both interrupt lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_cond | input | 128 | Condition nibble per lower queue, queue q at bits 4q+3:4q |
| low_uf | input | 32 | Under-run pulse per lower queue |
| low_of | input | 32 | Over-run pulse per lower queue |
| upp_ne | input | 32 | Nearly-empty level per upper queue |
| upp_full | input | 32 | Full level per upper queue |
| reg_wr | input | 1 | Write strobe, acts on the rising clock edge |
| reg_addr | input | 4 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_lo | output | 1 | Interrupt for queues 0 to 31 |
| irq_up | output | 1 | Interrupt for queues 32 to 63 |

## Verification
Two pairs of events can land in the same clock cycle.

The first pair is a hardware set and a software clear. The bench drives a queue's under-run pulse in the same cycle as a write that clears that bit. It also raises a queue's selected condition in latched mode in the same cycle as a write-1 to that queue's flag. In both cases the bit must read back as set afterwards. Neighbouring bits cleared by the same write must read back as clear.

The second pair is a held condition and a flag clear. Clearing a latched flag while its condition stays high must leave the flag clear.

// File: rtl/qsib_pkg.sv
package qsib_pkg;
    localparam int WORD_W         = 32;
    localparam int LOW_Q          = 32;
    localparam int UPP_Q          = 32;
    localparam int NIB_W          = 4;
    localparam int QPW_NIB        = WORD_W / NIB_W;
    localparam int LOW_STAT_WORDS = LOW_Q / QPW_NIB;
    localparam int UO_QPW         = WORD_W / 2;
    localparam int UO_WORDS       = LOW_Q / UO_QPW;
    localparam int ADDR_W         = 4;
    localparam int STICKY_BIT     = 3;

    // Word index map; the order is fixed because software walks it.
    typedef enum logic [ADDR_W-1:0] {
        A_LSTAT0 = 4'd0, A_LSTAT1, A_LSTAT2, A_LSTAT3,
        A_UO0, A_UO1,
        A_UNE, A_UFULL,
        A_SEL0, A_SEL1, A_SEL2, A_SEL3,
        A_EN_LO, A_EN_UP,
        A_FL_LO, A_FL_UP
    } reg_idx_e;

    typedef struct packed {
        logic full;
        logic nfull;
        logic nempty;
        logic empty;
    } qcond_t;

    typedef struct packed {
        logic       rsvd;
        logic       invert;
        logic [1:0] pick;
    } qsel_t;

    function automatic logic sel_cond(qcond_t c, qsel_t s);
        logic v;
        case (s.pick)
            2'd0:    v = c.empty;
            2'd1:    v = c.nempty;
            2'd2:    v = c.nfull;
            default: v = c.full;
        endcase
        return v ^ s.invert;
    endfunction
endpackage

// File: rtl/qsib_cond_select.sv
module qsib_cond_select
    import qsib_pkg::*;
#(
    parameter int NQ = LOW_Q
) (
    input  logic [NQ*NIB_W-1:0] cond_nib,
    input  logic [NQ*NIB_W-1:0] sel_nib,
    output logic [NQ-1:0]       cond_out
);
    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign cond_out[q] = sel_cond(qcond_t'(cond_nib[q*NIB_W +: NIB_W]),
                                      qsel_t'(sel_nib[q*NIB_W +: NIB_W]));
    end
endmodule

// File: rtl/qsib_uo_bank.sv
module qsib_uo_bank
    import qsib_pkg::*;
#(
    parameter int NQ = LOW_Q,
    localparam int NW = (2 * NQ) / WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NQ-1:0]     uf_pulse,
    input  logic [NQ-1:0]     of_pulse,
    input  logic [NW-1:0]     wr_word,
    input  logic [WORD_W-1:0] wdata,
    output logic [2*NQ-1:0]   bits
);
    logic [2*NQ-1:0] set_v;

    for (genvar q = 0; q < NQ; q++) begin : g_pair
        assign set_v[2*q]   = uf_pulse[q];
        assign set_v[2*q+1] = of_pulse[q];
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                bits[w*WORD_W +: WORD_W] <= '0;
            else if (wr_word[w])
                bits[w*WORD_W +: WORD_W] <= (bits[w*WORD_W +: WORD_W] & wdata)
                                            | set_v[w*WORD_W +: WORD_W];
            else
                bits[w*WORD_W +: WORD_W] <= bits[w*WORD_W +: WORD_W]
                                            | set_v[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/qsib_irq_group.sv
module qsib_irq_group #(
    parameter int NQ = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NQ-1:0] cond,
    input  logic [NQ-1:0] en,
    input  logic          sticky,
    input  logic          clr_wr,
    input  logic [NQ-1:0] clr_data,
    output logic [NQ-1:0] flags,
    output logic          irq
);
    logic [NQ-1:0] prev;
    logic [NQ-1:0] clr_mask;
    logic [NQ-1:0] rise;

    assign clr_mask = clr_wr ? clr_data : '0;
    assign rise     = cond & ~prev & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            flags <= '0;
        end else begin
            prev <= cond;
            if (sticky)
                flags <= (flags & ~clr_mask) | rise;
            else
                flags <= cond & en;
        end
    end

    assign irq = |flags;
endmodule

// File: rtl/qsib_irq_bank.sv
module qsib_irq_bank
    import qsib_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LOW_Q*NIB_W-1:0] low_cond,
    input  logic [LOW_Q-1:0]       low_uf,
    input  logic [LOW_Q-1:0]       low_of,
    input  logic [UPP_Q-1:0]       upp_ne,
    input  logic [UPP_Q-1:0]       upp_full,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]      reg_rdata,
    output logic                   irq_lo,
    output logic                   irq_up
);
    logic [LOW_Q*NIB_W-1:0] sel_q;
    logic [LOW_Q-1:0]       en_lo;
    logic [UPP_Q-1:0]       en_up;
    logic [2*LOW_Q-1:0]     uo_bits;
    logic [UO_WORDS-1:0]    uo_wr;
    logic [LOW_Q-1:0]       cond_lo;
    logic [LOW_Q-1:0]       flag_lo;
    logic [UPP_Q-1:0]       flag_up;
    logic                   sticky;

    assign sticky = sel_q[STICKY_BIT];

    // Configuration words: source fields and enables.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            en_lo <= '0;
            en_up <= '0;
        end else if (reg_wr) begin
            for (int w = 0; w < LOW_STAT_WORDS; w++)
                if (reg_addr == ADDR_W'(int'(A_SEL0) + w))
                    sel_q[w*WORD_W +: WORD_W] <= reg_wdata;
            if (reg_addr == A_EN_LO) en_lo <= reg_wdata[LOW_Q-1:0];
            if (reg_addr == A_EN_UP) en_up <= reg_wdata[UPP_Q-1:0];
        end
    end

    for (genvar w = 0; w < UO_WORDS; w++) begin : g_uowr
        assign uo_wr[w] = reg_wr && (reg_addr == ADDR_W'(int'(A_UO0) + w));
    end

    qsib_uo_bank #(.NQ(LOW_Q)) u_uo (
        .clk      (clk),
        .rst      (rst),
        .uf_pulse (low_uf),
        .of_pulse (low_of),
        .wr_word  (uo_wr),
        .wdata    (reg_wdata),
        .bits     (uo_bits)
    );

    qsib_cond_select #(.NQ(LOW_Q)) u_sel (
        .cond_nib (low_cond),
        .sel_nib  (sel_q),
        .cond_out (cond_lo)
    );

    qsib_irq_group #(.NQ(LOW_Q)) u_grp_lo (
        .clk      (clk),
        .rst      (rst),
        .cond     (cond_lo),
        .en       (en_lo),
        .sticky   (sticky),
        .clr_wr   (reg_wr && reg_addr == A_FL_LO),
        .clr_data (reg_wdata[LOW_Q-1:0]),
        .flags    (flag_lo),
        .irq      (irq_lo)
    );

    // Upper group: source is fixed to nearly-empty.
    qsib_irq_group #(.NQ(UPP_Q)) u_grp_up (
        .clk      (clk),
        .rst      (rst),
        .cond     (upp_ne),
        .en       (en_up),
        .sticky   (sticky),
        .clr_wr   (reg_wr && reg_addr == A_FL_UP),
        .clr_data (reg_wdata[UPP_Q-1:0]),
        .flags    (flag_up),
        .irq      (irq_up)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_LSTAT0, A_LSTAT1, A_LSTAT2, A_LSTAT3:
                reg_rdata = low_cond[reg_addr[1:0]*WORD_W +: WORD_W];
            A_UO0, A_UO1:
                reg_rdata = uo_bits[reg_addr[0]*WORD_W +: WORD_W];
            A_UNE:   reg_rdata = upp_ne;
            A_UFULL: reg_rdata = upp_full;
            A_SEL0, A_SEL1, A_SEL2, A_SEL3:
                reg_rdata = sel_q[reg_addr[1:0]*WORD_W +: WORD_W];
            A_EN_LO: reg_rdata = en_lo;
            A_EN_UP: reg_rdata = en_up;
            A_FL_LO: reg_rdata = flag_lo;
            default: reg_rdata = flag_up;
        endcase
    end
endmodule

// File: rtl/qsib_irq_bank_chk.sv
module qsib_irq_bank_chk
    import qsib_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [LOW_Q-1:0]   low_uf,
    input logic [LOW_Q-1:0]   low_of,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [2*LOW_Q-1:0] uo_bits,
    input logic [LOW_Q-1:0]   flag_lo,
    input logic [UPP_Q-1:0]   flag_up,
    input logic [UPP_Q-1:0]   en_up,
    input logic               sticky,
    input logic               irq_lo
);
    logic [2*LOW_Q-1:0] ev;
    logic               uo_write;
    logic               fl_lo_write;

    always_comb begin
        for (int q = 0; q < LOW_Q; q++) begin
            ev[2*q]   = low_uf[q];
            ev[2*q+1] = low_of[q];
        end
    end

    assign uo_write    = reg_wr && (reg_addr == A_UO0 || reg_addr == A_UO1);
    assign fl_lo_write = reg_wr && (reg_addr == A_FL_LO);

    AST_UO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((uo_bits & $past(ev)) == $past(ev))); // R2

    AST_UO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !uo_write |=> ((uo_bits & $past(uo_bits)) == $past(uo_bits))); // R3

    AST_LEVEL_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !sticky |=> ((flag_up & ~$past(en_up)) == '0)); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sticky && !fl_lo_write) |=> ((flag_lo & $past(flag_lo)) == $past(flag_lo))); // R7

    AST_IRQ_LO_OR: assert property (@(posedge clk) disable iff (rst)
        irq_lo == (flag_lo != '0)); // R9
endmodule

bind qsib_irq_bank qsib_irq_bank_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .low_uf   (low_uf),
    .low_of   (low_of),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .uo_bits  (uo_bits),
    .flag_lo  (flag_lo),
    .flag_up  (flag_up),
    .en_up    (en_up),
    .sticky   (sticky),
    .irq_lo   (irq_lo)
);

// File: tb/qsib_irq_bank_tb_top.sv
module qsib_irq_bank_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] low_cond = '0;
    logic [31:0]  low_uf = '0, low_of = '0, upp_ne = '0, upp_full = '0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq_lo, irq_up;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    qsib_irq_bank dut_i (
        .clk(clk), .rst(rst), .low_cond(low_cond), .low_uf(low_uf), .low_of(low_of),
        .upp_ne(upp_ne), .upp_full(upp_full), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_up(irq_up)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [3:0] nib(input int q, input int p, input int c);
        return 4'((q * 5 + p * 3 + c) & 15);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state of stored words and interrupt lines
        foreach (d[i]) ; // no-op to keep loop style local
        for (int a = 4; a < 16; a++) begin
            if (a == 6 || a == 7) continue;
            rd(4'(a), d);
            chk($sformatf("R10 word %0d", a), d, 32'h0);
        end
        chk("R10 irq_lo", {31'b0, irq_lo}, 32'h0);
        chk("R10 irq_up", {31'b0, irq_up}, 32'h0);

        // R1: nibble packing, several patterns, and read-only words
        for (int p = 0; p < 3; p++) begin
            @(negedge clk);
            for (int q = 0; q < 32; q++) low_cond[q*4 +: 4] = nib(q, p, 1);
            for (int w = 0; w < 4; w++) begin
                e = '0;
                for (int k = 0; k < 8; k++) e[k*4 +: 4] = nib(w*8 + k, p, 1);
                rd(4'(w), d);
                chk($sformatf("R1 word %0d pattern %0d", w, p), d, e);
            end
        end
        wr(4'd2, 32'hFFFF_FFFF);
        e = '0;
        for (int k = 0; k < 8; k++) e[k*4 +: 4] = nib(16 + k, 2, 1);
        rd(4'd2, d);
        chk("R1 write ignored", d, e);

        // R4: upper status words
        @(negedge clk);
        upp_ne = 32'hC3A5_0F81; upp_full = 32'h1248_8421;
        rd(4'd6, d); chk("R4 nearly-empty word", d, 32'hC3A5_0F81);
        rd(4'd7, d); chk("R4 full word", d, 32'h1248_8421);
        wr(4'd7, 32'h0);
        rd(4'd7, d); chk("R4 full write ignored", d, 32'h1248_8421);
        @(negedge clk); upp_ne = '0; upp_full = '0;

        // R2/R3: capture and write-zero clear for every lower queue
        for (int q = 0; q < 32; q++) begin
            @(negedge clk); low_uf[q] = 1'b1; low_of[(q + 7) % 32] = 1'b1;
            @(negedge clk); low_uf = '0; low_of = '0;
            e = 32'h1 << (2 * (q % 16));
            if (((q + 7) % 32) / 16 == q / 16) e |= 32'h2 << (2 * (((q + 7) % 32) % 16));
            rd(4'(4 + q / 16), d);
            chk($sformatf("R2 capture q%0d", q), d, e);
            wr(4'd4, 32'h0); wr(4'd5, 32'h0);
            rd(4'(4 + q / 16), d);
            chk($sformatf("R3 cleared q%0d", q), d, 32'h0);
        end
        // R3: write 1 keeps, write 0 clears, pulse wins over clearing write
        @(negedge clk); low_uf[3] = 1'b1; low_of[4] = 1'b1;
        @(negedge clk); low_uf = '0; low_of = '0;
        wr(4'd4, ~(32'h1 << 6)); // clear uf3, keep of4
        rd(4'd4, d); chk("R3 selective clear", d, 32'h200);
        @(negedge clk);
        low_uf[3] = 1'b1; reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0;
        @(negedge clk);
        low_uf = '0; reg_wr = 1'b0;
        rd(4'd4, d); chk("R3 pulse beats clear", d, 32'h40);
        wr(4'd4, 32'h0);

        // R5/R6: level mode, every select code, several condition patterns
        wr(4'd12, 32'hA5A5_F00F);
        for (int c = 0; c < 8; c++) begin
            for (int w = 0; w < 4; w++) wr(4'(8 + w), 32'h1111_1111 * c);
            rd(4'd9, d); chk($sformatf("R5 readback code %0d", c), d, 32'h1111_1111 * c);
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                for (int q = 0; q < 32; q++) low_cond[q*4 +: 4] = nib(q, p, c);
                @(negedge clk);
                e = '0;
                for (int q = 0; q < 32; q++)
                    e[q] = nib(q, p, c)[c & 3] ^ c[2];
                e &= 32'hA5A5_F00F;
                rd(4'd14, d);
                chk($sformatf("R6 flags code %0d pattern %0d", c, p), d, e);
                chk($sformatf("R9 irq_lo code %0d pattern %0d", c, p), {31'b0, irq_lo}, {31'b0, e != 0});
            end
        end
        // R6: flag write has no lasting effect in level mode
        @(negedge clk); low_cond = '0;
        for (int w = 0; w < 4; w++) wr(4'(8 + w), 32'h1111_1111);
        wr(4'd14, 32'hFFFF_FFFF);
        rd(4'd14, d); chk("R6 flag write ignored", d, 32'h0);

        // R8/R6/R9: upper group follows nearly-empty only
        wr(4'd13, 32'hFFFF_0000);
        @(negedge clk); upp_ne = 32'h0030_8001; upp_full = 32'hFFFF_FFFF;
        @(negedge clk);
        rd(4'd15, d); chk("R8 upper flags", d, 32'h0030_0000);
        chk("R9 irq_up", {31'b0, irq_up}, 32'h1);
        @(negedge clk); upp_ne = 32'h0000_8001;
        @(negedge clk);
        rd(4'd15, d); chk("R8 upper flags masked", d, 32'h0);
        chk("R9 irq_up low", {31'b0, irq_up}, 32'h0);
        @(negedge clk); upp_ne = '0; upp_full = '0;

        // R7: latched mode, nearly-empty source, queue 7 disabled
        wr(4'd12, ~(32'h1 << 7));
        wr(4'd8, 32'h1111_1119);
        rd(4'd14, d); chk("R7 entry flags", d, 32'h0);
        @(negedge clk); low_cond[5*4 +: 4] = 4'b0010; low_cond[7*4 +: 4] = 4'b0010;
        @(negedge clk);
        rd(4'd14, d); chk("R7 edge sets, disabled ignored", d, 32'h20);
        @(negedge clk); low_cond[5*4 +: 4] = 4'b0000;
        repeat (2) @(negedge clk);
        rd(4'd14, d); chk("R7 holds after drop", d, 32'h20);
        @(negedge clk); low_cond[5*4 +: 4] = 4'b0010;
        wr(4'd14, 32'h20);
        repeat (2) @(negedge clk);
        rd(4'd14, d); chk("R7 cleared, held level no reset", d, 32'h0);
        chk("R9 irq_lo cleared", {31'b0, irq_lo}, 32'h0);
        @(negedge clk);
        low_cond[6*4 +: 4] = 4'b0010;
        reg_wr = 1'b1; reg_addr = 4'd14; reg_wdata = 32'h40;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(4'd14, d); chk("R7 edge beats clear", d, 32'h40);
        chk("R9 irq_lo latched", {31'b0, irq_lo}, 32'h1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule